// File: doc/BRIEF.md
# Zoned External Bus Read Sequencer

This block turns one read request from a core into a timed read cycle on an external memory or I/O bus. The address space is split into zones. Each zone has its own data-bus width (8 or 16 lines), number of internal wait states, number of hold states, and two burst controls. When a request is accepted, the block latches that zone's settings. It then steps through a fixed series of bus states: an address state, the internal waits, a sample state, an optional burst wait and burst sample, and the hold states. While it does so it drives the address, a one-hot zone select, an active-high read strobe and two write strobes that stay inactive.

A 16-bit read from an 8-bit zone that has burst enabled gets a second sample at the next byte address, and the two bytes are combined into one word. The core sees a valid/ready request handshake. The result comes back as a one-cycle done pulse with the assembled data. A request can be accepted in the last state of the current cycle, so back-to-back reads run with no idle state between them. When both reads are to the same zone, the select does not drop.

Top module: `zbr_rd_seq`

## Requirements
- R1: On the first clock after a request is accepted, the bus state is T1 (code 1). The latched address is on the address bus, the select bit of the requested zone is high, and the read strobe is low.
- R2: The two active-low write strobes `bus_wr_n` stay at 2'b11 in every cycle.
- R3: After T1 come exactly as many TIW states (code 2) as the zone's wait count, then one T2 state (code 3). The read strobe first goes high in the first TIW, or in T2 when the wait count is zero. The read strobe is high only in TIW, T2, TBW and T2B.
- R4: The data lines are sampled at the end of T2. A 16-bit zone returns all 16 lines for a word request. Otherwise only lines 7:0 are kept and the upper byte is zero. The exception is a burst, which fills the upper byte (see R7).
- R5: After the last sample state come exactly as many THOLD states (code 6) as the zone's hold count. During THOLD the select and the read strobe are low and the address of the last sample stays on the bus.
- R6: When the hold count is zero and a new request is waiting, T1 of the new cycle follows the last sample state directly. For a request to the same zone the select stays high without a gap. With no request waiting, the bus goes to Idle (code 0) with every select low.
- R7: A word request to an 8-bit zone with burst enabled adds a T2B state (code 5) after T2 and before any hold states. T2B drives the address plus one (wrapping at the address width). Lines 7:0 sampled at the end of T2B become the upper byte, and the T2 sample is the lower byte.
- R8: If the zone's burst-wait bit is set, one TBW state (code 4) comes between T2 and T2B. TBW already drives the address plus one. The read strobe stays high through TBW and T2B and goes low in the clock after T2B.
- R9: `done` is high for exactly one cycle: the cycle after the final sample state (T2, or T2B for a burst). In that cycle `done_data` holds the assembled word.
- R10: `req_ready` is high in Idle and in the last state of a cycle, and low otherwise. The last state is a final sample state with zero hold, or the last THOLD. Request inputs are ignored while it is low.
- R11: At most one zone select is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core read request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_zone | input | ZONE_W | Target zone index |
| req_addr | input | ADDR_W | Byte address of the read |
| req_word | input | 1 | 1 = 16-bit read, 0 = byte read |
| cfg_wide | input | NZONES | Per zone: 1 = 16-bit data bus |
| cfg_burst_en | input | NZONES | Per zone: allow burst for wide reads on a narrow bus |
| cfg_burst_wait | input | NZONES | Per zone: add TBW before T2B |
| cfg_iwait | input | NZONES*IW_W | Per zone internal wait count, zone i at bits i*IW_W |
| cfg_hold | input | NZONES*HOLD_W | Per zone hold count, zone i at bits i*HOLD_W |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | DATA_W | Assembled read data |
| bus_addr | output | ADDR_W | External address bus |
| bus_sel | output | NZONES | Active-high zone selects |
| bus_rd | output | 1 | Active-high read strobe |
| bus_wr_n | output | 2 | Active-low byte write strobes, always inactive |
| bus_data | input | DATA_W | External data lines |
| bus_state | output | 3 | Current bus state code |

## Verification
The bench targets three kinds of errors. First, an off-by-one in the wait or hold counters, which would add or drop a TIW or THOLD state and shift the read strobe and the done pulse by a cycle. Second, back-to-back reads with zero hold: a design that wrongly passes through Idle shows a select gap and a late T1. Third, burst cases, including an address that wraps at the top of the space and bursts with and without TBW. A design that advances the address too late, samples the wrong byte lane, or runs a burst on a 16-bit zone or for a byte request gives a wrong address during TBW/T2B, a wrong upper byte, or extra states.

// File: rtl/zbr_pkg.sv
package zbr_pkg;

    typedef enum logic [2:0] {
        BS_IDLE = 3'd0,
        BS_T1   = 3'd1,
        BS_TIW  = 3'd2,
        BS_T2   = 3'd3,
        BS_TBW  = 3'd4,
        BS_T2B  = 3'd5,
        BS_HOLD = 3'd6
    } bus_state_e;

    typedef struct packed {
        logic wide;
        logic burst_en;
        logic burst_wait;
    } zone_flags_t;

    // A burst phase is needed when the core wants a word from a byte-wide zone
    function automatic logic needs_burst(input zone_flags_t f, input logic word);
        return word && !f.wide && f.burst_en;
    endfunction

    function automatic logic strobe_active(input bus_state_e s);
        return (s == BS_TIW) || (s == BS_T2) || (s == BS_TBW) || (s == BS_T2B);
    endfunction

    function automatic logic select_active(input bus_state_e s);
        return strobe_active(s) || (s == BS_T1);
    endfunction

endpackage

// File: rtl/zbr_cfg_mux.sv
module zbr_cfg_mux
    import zbr_pkg::*;
#(
    parameter int NZONES = 4,
    parameter int IW_W   = 3,
    parameter int HOLD_W = 3,
    localparam int ZONE_W = (NZONES > 1) ? $clog2(NZONES) : 1
) (
    input  logic [ZONE_W-1:0]        zone,
    input  logic [NZONES-1:0]        cfg_wide,
    input  logic [NZONES-1:0]        cfg_burst_en,
    input  logic [NZONES-1:0]        cfg_burst_wait,
    input  logic [NZONES*IW_W-1:0]   cfg_iwait,
    input  logic [NZONES*HOLD_W-1:0] cfg_hold,
    output zone_flags_t              flags,
    output logic [IW_W-1:0]          iw,
    output logic [HOLD_W-1:0]        hold
);

    zone_flags_t       flag_a [NZONES];
    logic [IW_W-1:0]   iw_a   [NZONES];
    logic [HOLD_W-1:0] hold_a [NZONES];

    for (genvar i = 0; i < NZONES; i++) begin : g_zone
        assign flag_a[i] = '{wide: cfg_wide[i], burst_en: cfg_burst_en[i],
                             burst_wait: cfg_burst_wait[i]};
        assign iw_a[i]   = cfg_iwait[i*IW_W +: IW_W];
        assign hold_a[i] = cfg_hold[i*HOLD_W +: HOLD_W];
    end

    assign flags = flag_a[zone];
    assign iw    = iw_a[zone];
    assign hold  = hold_a[zone];

endmodule

// File: rtl/zbr_fsm.sv
module zbr_fsm
    import zbr_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int NZONES = 4,
    parameter int IW_W   = 3,
    parameter int HOLD_W = 3,
    localparam int ZONE_W = (NZONES > 1) ? $clog2(NZONES) : 1,
    localparam int CNT_W  = (IW_W > HOLD_W) ? IW_W : HOLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ZONE_W-1:0] req_zone,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  zone_flags_t       new_flags,
    input  logic [IW_W-1:0]   new_iw,
    input  logic [HOLD_W-1:0] new_hold,
    output logic              req_ready,
    output bus_state_e        state,
    output logic [ZONE_W-1:0] cur_zone,
    output logic [ADDR_W-1:0] cur_addr,
    output zone_flags_t       cur_flags,
    output logic              cur_word,
    output logic              fin_now
);

    bus_state_e        state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic              adv, adv_n;
    logic [ADDR_W-1:0] base_addr;
    logic [IW_W-1:0]   cur_iw;
    logic [HOLD_W-1:0] cur_hold;
    logic              burst, end_now, accept;

    always_comb begin
        burst     = needs_burst(cur_flags, cur_word);
        fin_now   = ((state == BS_T2) && !burst) || (state == BS_T2B);
        end_now   = (fin_now && (cur_hold == '0)) ||
                    ((state == BS_HOLD) && (cnt == CNT_W'(1)));
        req_ready = (state == BS_IDLE) || end_now;
        accept    = req_valid && req_ready;
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        adv_n   = adv;
        unique case (state)
            BS_T1: begin
                if (cur_iw != '0) begin
                    state_n = BS_TIW;
                    cnt_n   = CNT_W'(cur_iw);
                end else begin
                    state_n = BS_T2;
                end
            end
            BS_TIW: begin
                if (cnt == CNT_W'(1)) state_n = BS_T2;
                else                   cnt_n   = cnt - CNT_W'(1);
            end
            BS_T2: begin
                if (burst) begin
                    state_n = cur_flags.burst_wait ? BS_TBW : BS_T2B;
                    adv_n   = 1'b1;
                end
            end
            BS_TBW:  state_n = BS_T2B;
            BS_HOLD: begin
                if (cnt != CNT_W'(1)) cnt_n = cnt - CNT_W'(1);
            end
            default: ;
        endcase
        if (fin_now && (cur_hold != '0)) begin
            state_n = BS_HOLD;
            cnt_n   = CNT_W'(cur_hold);
        end
        if (end_now) state_n = BS_IDLE;
        if (accept) begin
            state_n = BS_T1;
            adv_n   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= BS_IDLE;
            cnt       <= '0;
            adv       <= 1'b0;
            base_addr <= '0;
            cur_zone  <= '0;
            cur_flags <= '0;
            cur_word  <= 1'b0;
            cur_iw    <= '0;
            cur_hold  <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            adv   <= adv_n;
            if (accept) begin
                base_addr <= req_addr;
                cur_zone  <= req_zone;
                cur_flags <= new_flags;
                cur_word  <= req_word;
                cur_iw    <= new_iw;
                cur_hold  <= new_hold;
            end
        end
    end

    assign cur_addr = base_addr + ADDR_W'(adv);

endmodule

// File: rtl/zbr_capture.sv
module zbr_capture
    import zbr_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_state_e        state,
    input  logic              fin_now,
    input  zone_flags_t       flags,
    input  logic              word,
    input  logic [DATA_W-1:0] bus_data,
    output logic              done,
    output logic [DATA_W-1:0] done_data
);

    logic [HALF_W-1:0] lo_q, hi_q;
    logic              keep_upper;

    assign keep_upper = flags.wide && word;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
            done <= 1'b0;
        end else begin
            done <= fin_now;
            if (state == BS_T2) begin
                lo_q <= bus_data[HALF_W-1:0];
                hi_q <= keep_upper ? bus_data[DATA_W-1:HALF_W] : '0;
            end
            if (state == BS_T2B) begin
                hi_q <= bus_data[HALF_W-1:0];
            end
        end
    end

    assign done_data = {hi_q, lo_q};

endmodule

// File: rtl/zbr_rd_seq.sv
module zbr_rd_seq
    import zbr_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16,
    parameter int NZONES = 4,
    parameter int IW_W   = 3,
    parameter int HOLD_W = 3,
    localparam int ZONE_W = (NZONES > 1) ? $clog2(NZONES) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ZONE_W-1:0]        req_zone,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_word,
    input  logic [NZONES-1:0]        cfg_wide,
    input  logic [NZONES-1:0]        cfg_burst_en,
    input  logic [NZONES-1:0]        cfg_burst_wait,
    input  logic [NZONES*IW_W-1:0]   cfg_iwait,
    input  logic [NZONES*HOLD_W-1:0] cfg_hold,
    output logic                     done,
    output logic [DATA_W-1:0]        done_data,
    output logic [ADDR_W-1:0]        bus_addr,
    output logic [NZONES-1:0]        bus_sel,
    output logic                     bus_rd,
    output logic [1:0]               bus_wr_n,
    input  logic [DATA_W-1:0]        bus_data,
    output logic [2:0]               bus_state
);

    zone_flags_t       new_flags, cur_flags;
    logic [IW_W-1:0]   new_iw;
    logic [HOLD_W-1:0] new_hold;
    bus_state_e        state;
    logic [ZONE_W-1:0] cur_zone;
    logic              cur_word, fin_now, drive_sel;

    zbr_cfg_mux #(.NZONES(NZONES), .IW_W(IW_W), .HOLD_W(HOLD_W)) u_cfg (
        .zone(req_zone), .cfg_wide(cfg_wide), .cfg_burst_en(cfg_burst_en),
        .cfg_burst_wait(cfg_burst_wait), .cfg_iwait(cfg_iwait), .cfg_hold(cfg_hold),
        .flags(new_flags), .iw(new_iw), .hold(new_hold)
    );

    zbr_fsm #(.ADDR_W(ADDR_W), .NZONES(NZONES), .IW_W(IW_W), .HOLD_W(HOLD_W)) u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_zone(req_zone),
        .req_addr(req_addr), .req_word(req_word), .new_flags(new_flags),
        .new_iw(new_iw), .new_hold(new_hold), .req_ready(req_ready),
        .state(state), .cur_zone(cur_zone), .cur_addr(bus_addr),
        .cur_flags(cur_flags), .cur_word(cur_word), .fin_now(fin_now)
    );

    zbr_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .state(state), .fin_now(fin_now),
        .flags(cur_flags), .word(cur_word), .bus_data(bus_data),
        .done(done), .done_data(done_data)
    );

    assign drive_sel = select_active(state);
    for (genvar i = 0; i < NZONES; i++) begin : g_sel
        assign bus_sel[i] = drive_sel && (cur_zone == ZONE_W'(i));
    end

    assign bus_rd    = strobe_active(state);
    assign bus_wr_n  = '1;
    assign bus_state = state;

endmodule

// File: rtl/zbr_rd_seq_chk.sv
module zbr_rd_seq_chk
    import zbr_pkg::*;
#(
    parameter int NZONES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              done,
    input logic [NZONES-1:0] bus_sel,
    input logic              bus_rd,
    input logic [2:0]        bus_state
);

    assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_sel));

    assert_t1_no_read_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_state == BS_T1) |-> (!bus_rd && (bus_sel != '0)));

    assert_rd_states_R3: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> ((bus_state == BS_TIW) || (bus_state == BS_T2) ||
                    (bus_state == BS_TBW) || (bus_state == BS_T2B)));

    assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_state == BS_HOLD) |-> (!bus_rd && (bus_sel == '0)));

    assert_tbw_to_t2b_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_state == BS_TBW) |=> (bus_state == BS_T2B));

    assert_done_after_t2b_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_state == BS_T2B) |=> done);

    assert_ready_states_R10: assert property (@(posedge clk) disable iff (rst)
        (req_ready && (bus_state != BS_IDLE)) |->
        ((bus_state == BS_T2) || (bus_state == BS_T2B) || (bus_state == BS_HOLD)));

endmodule

bind zbr_rd_seq zbr_rd_seq_chk #(.NZONES(NZONES)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .done(done),
    .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_state(bus_state)
);

// File: tb/sim_zbr_rd_seq.sv
module sim_zbr_rd_seq;

    localparam int AW = 19;
    localparam int DW = 16;
    localparam int NZ = 4;
    localparam int IWW = 3;
    localparam int HW = 3;

    typedef struct {
        int    st;
        int    sel;
        bit    rd;
        int    addr;
        bit    dn;
        int    data;
        string tag;
    } exp_t;

    typedef struct {
        int z;
        int a;
        bit w;
    } req_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_zone = '0;
    logic [AW-1:0] req_addr = '0;
    logic req_word = 1'b0;
    logic [NZ-1:0] cfg_wide, cfg_burst_en, cfg_burst_wait;
    logic [NZ*IWW-1:0] cfg_iwait;
    logic [NZ*HW-1:0] cfg_hold;
    logic done;
    logic [DW-1:0] done_data;
    logic [AW-1:0] bus_addr;
    logic [NZ-1:0] bus_sel;
    logic bus_rd;
    logic [1:0] bus_wr_n;
    logic [DW-1:0] bus_data;
    logic [2:0] bus_state;

    int c_wide[NZ], c_be[NZ], c_bw[NZ], c_iw[NZ], c_hold[NZ];
    exp_t q[$];
    req_t pend[$];
    int checks = 0, errors = 0, cycles = 0;
    bit exp_done = 0;
    int exp_data = 0;

    always #2.5 clk = ~clk;

    // memory model: data depends on the address lines only
    function automatic int mem(input int a);
        logic [7:0] b;
        b = a[7:0];
        return {16'h0, b ^ 8'hA5, b + 8'h3C};
    endfunction

    assign bus_data = 16'(mem(int'(bus_addr)));

    zbr_rd_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_zone(req_zone), .req_addr(req_addr), .req_word(req_word),
        .cfg_wide(cfg_wide), .cfg_burst_en(cfg_burst_en), .cfg_burst_wait(cfg_burst_wait),
        .cfg_iwait(cfg_iwait), .cfg_hold(cfg_hold), .done(done), .done_data(done_data),
        .bus_addr(bus_addr), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr_n(bus_wr_n),
        .bus_data(bus_data), .bus_state(bus_state)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    task automatic apply_cfg();
        for (int i = 0; i < NZ; i++) begin
            cfg_wide[i]       = c_wide[i][0];
            cfg_burst_en[i]   = c_be[i][0];
            cfg_burst_wait[i] = c_bw[i][0];
            cfg_iwait[i*IWW +: IWW] = IWW'(c_iw[i]);
            cfg_hold[i*HW +: HW]    = HW'(c_hold[i]);
        end
    endtask

    function automatic exp_t mk(int st, int sel, bit rd, int addr, string tag);
        exp_t e;
        e.st = st; e.sel = sel; e.rd = rd; e.addr = addr;
        e.dn = 0; e.data = 0; e.tag = tag;
        return e;
    endfunction

    task automatic build(input req_t r);
        int a2, sel, lo, hi, last_a;
        bit burst;
        exp_t e;
        a2 = (r.a + 1) & ((1 << AW) - 1);
        sel = 1 << r.z;
        burst = r.w && !c_wide[r.z][0] && c_be[r.z][0];
        lo = mem(r.a) & 8'hFF;
        if (burst) hi = mem(a2) & 8'hFF;
        else if (r.w && c_wide[r.z][0]) hi = (mem(r.a) >> 8) & 8'hFF;
        else hi = 0;
        q.push_back(mk(1, sel, 0, r.a, "R1"));
        for (int i = 0; i < c_iw[r.z]; i++) q.push_back(mk(2, sel, 1, r.a, "R3"));
        e = mk(3, sel, 1, r.a, "R3");
        last_a = r.a;
        if (!burst) begin e.dn = 1; e.data = (hi << 8) | lo; end
        q.push_back(e);
        if (burst) begin
            if (c_bw[r.z][0]) q.push_back(mk(4, sel, 1, a2, "R8"));
            e = mk(5, sel, 1, a2, "R7");
            e.dn = 1; e.data = (hi << 8) | lo;
            q.push_back(e);
            last_a = a2;
        end
        for (int i = 0; i < c_hold[r.z]; i++) q.push_back(mk(6, 0, 0, last_a, "R5"));
    endtask

    task automatic step();
        exp_t e;
        bit was_done;
        @(negedge clk);
        cycles++;
        if (q.size() > 0) e = q.pop_front();
        else e = mk(0, 0, 0, 0, "R6");
        check({e.tag, " state"}, int'(bus_state), e.st);
        check({e.tag, " select"}, int'(bus_sel), e.sel);
        check({e.tag, " read strobe"}, int'(bus_rd), int'(e.rd));
        if (e.st != 0) check({e.tag, " address"}, int'(bus_addr), e.addr);
        check("R2 write strobes", int'(bus_wr_n), 3);
        check("R9 done pulse", int'(done), int'(exp_done));
        if (exp_done) check("R9 R4 R7 done data", int'(done_data), exp_data);
        check("R10 ready", int'(req_ready), int'(q.size() == 0));
        was_done = e.dn;
        exp_done = was_done;
        exp_data = e.data;
        if (q.size() == 0 && pend.size() > 0) begin
            req_t r;
            r = pend.pop_front();
            req_valid = 1'b1;
            req_zone = 2'(r.z);
            req_addr = AW'(r.a);
            req_word = r.w;
            build(r);
        end else begin
            // R10: junk on the request lines while not ready must be ignored
            req_valid = (pend.size() > 0);
            req_zone = 2'(cycles);
            req_addr = AW'(cycles * 977);
            req_word = cycles[0];
        end
    endtask

    task automatic drain();
        while ((pend.size() > 0 || q.size() > 0 || exp_done) && cycles < 5000) step();
        for (int i = 0; i < 3; i++) step();
        req_valid = 1'b0;
    endtask

    function automatic req_t rq(int z, int a, bit w);
        req_t r;
        r.z = z; r.a = a; r.w = w;
        return r;
    endfunction

    initial begin
        // phase A: z0 wide, z1 burst+wait, z2 burst no wait, z3 narrow no burst
        c_wide = '{1, 0, 0, 0}; c_be = '{0, 1, 1, 0}; c_bw = '{0, 1, 0, 1};
        c_iw = '{0, 2, 1, 0};   c_hold = '{0, 1, 0, 2};
        apply_cfg();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset ready", int'(req_ready), 1);
        check("R6 reset state idle", int'(bus_state), 0);
        check("R9 reset done", int'(done), 0);
        pend.push_back(rq(0, 'h00010, 1));   // R6 same-zone back-to-back, zero hold
        pend.push_back(rq(0, 'h00011, 1));
        pend.push_back(rq(0, 'h7FFFF, 0));   // R4 byte read on wide zone
        pend.push_back(rq(1, 'h1234F, 1));   // R8 burst with TBW, R5 hold
        pend.push_back(rq(2, 'h0FF00, 1));   // R7 burst without TBW
        pend.push_back(rq(2, 'h0FF02, 1));
        pend.push_back(rq(3, 'h00500, 1));   // R4 word on narrow zone, no burst
        pend.push_back(rq(3, 'h00501, 0));
        pend.push_back(rq(2, 'h00777, 0));   // R7 byte read: no burst
        pend.push_back(rq(1, 'h7FFFF, 1));   // R7 burst address wraps
        pend.push_back(rq(0, 'h00123, 1));   // R6 different zones back-to-back
        pend.push_back(rq(2, 'h00124, 1));
        drain();
        // phase B: long waits and holds, wide zone with burst enabled
        c_wide = '{0, 1, 0, 1}; c_be = '{1, 1, 0, 0}; c_bw = '{1, 1, 1, 0};
        c_iw = '{7, 1, 3, 0};   c_hold = '{7, 0, 1, 0};
        apply_cfg();
        pend.push_back(rq(0, 'h2AAAA, 1));
        pend.push_back(rq(1, 'h05555, 1));   // wide zone: no burst despite enable
        pend.push_back(rq(1, 'h05556, 1));
        pend.push_back(rq(2, 'h0ABCD, 1));   // burst disabled with wait bit set
        pend.push_back(rq(3, 'h00042, 1));
        pend.push_back(rq(3, 'h00043, 0));
        drain();
        if (cycles >= 5000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<5000 cycles", cycles);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule